// File: doc/BRIEF.md
# Capture/Compare Down-Counting Timer

This block is a byte-wide timer slice. A synchronous down counter runs from a programmed period value to zero, then reloads the period and keeps going. The result is a repeating cycle of period+1 clocks. The cycle in which the counter is at zero is the terminal count, which drives the primary output. A single capture/compare register does two jobs. A comparator checks the live count against it to drive the auxiliary output. A capture event overwrites it with the live count.

A capture is started either by a rising edge on the capture input or by a software read of the count register while the timer runs. Both requests are merged before one shared rising-edge detector. As a result, a software read made while the capture input is held high is lost. Software uses a small register interface to set the period, the compare value and the control bits. The control bits select the compare type, the interrupt source and the terminal-count pulse width. The capture input is assumed to be synchronous to the clock.

Register map (2-bit address): 0 = count (read only), 1 = period, 2 = capture/compare, 3 = control. Control bits: bit 0 run enable, bit 1 interrupt source (0 terminal count, 1 compare), bit 2 compare type (0 count <= register, 1 count < register), bit 3 capture interrupt enable, bit 4 terminal-count width (0 half cycle, 1 full cycle).

Top module: `cap_cmp_timer`

## Requirements
- R1: After synchronous reset all four registers read 0, and tc_out, cmp_out and irq_out are low.
- R2: A period write (address 1) while stopped loads the same value into the count. A period write while running leaves the count on its normal path and only changes the value used at the next reload.
- R3: While running, the count drops by one on each clock. In the clock after the count reaches 0 it takes the period value, giving a repeat length of period+1 clocks. While stopped the count holds.
- R4: tc_out is high while the timer runs and the count is 0. With control bit 4 = 1 it is high for the whole clock. With bit 4 = 0 it is high only in the low phase of the clock.
- R5: A rising edge of cap_in copies the count present at that clock into the capture/compare register. Holding cap_in high does not capture again.
- R6: A read strobe (rd_en) at address 0 while running captures the same way as a hardware edge. No capture happens when it arrives while cap_in is high or while the timer is stopped.
- R7: While running, cmp_out is high when count <= capture/compare (control bit 2 = 0) or when count < capture/compare (bit 2 = 1). It is low while stopped.
- R8: A write to the capture/compare register (address 2) takes effect only while stopped. While running it is ignored.
- R9: With control bit 1 = 0, irq_out pulses on the rising edge of terminal count, in the same phase as tc_out. With bit 1 = 1, irq_out pulses for one clock on the rising edge of cmp_out.
- R10: With control bit 3 = 1, irq_out is also high for one clock, in the clock in which the captured value first appears in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (address 0 read triggers software capture) |
| addr | input | 2 | Register address |
| wdata | input | W | Write data |
| cap_in | input | 1 | Hardware capture request, rising-edge sensitive |
| rdata | output | W | Read data for the addressed register |
| tc_out | output | 1 | Terminal count (primary output) |
| cmp_out | output | 1 | Compare result (auxiliary output) |
| irq_out | output | 1 | Selected interrupt |

## Verification
The hardest case to reach is the masking of a software capture. It needs a count read to arrive while cap_in is already high from an earlier edge. The read must also come after the counter has moved on, so that a wrongly accepted capture would leave a different value behind. The stimulus raises cap_in on a running timer and holds it for several clocks. It then issues a count read and confirms that the register still holds the first capture. Next it drops cap_in for one clock and issues another read, which must now capture. A similar sequence covers the half-cycle terminal-count case. There the bench samples tc_out once in the high phase, expecting it masked, and once in the low phase, expecting it visible, both in the same zero-count clock.

// File: rtl/cct_pkg.sv
// Package: shared constants and the control register layout for the
// capture/compare timer. Assumes a 2-bit register address.
package cct_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_CAPCMP = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd3;

    // Control register; run enable sits in bit 0, width select in bit 4.
    typedef struct packed {
        logic tc_full;     // bit 4: full-cycle terminal count
        logic cap_irq_en;  // bit 3: interrupt on capture
        logic cmp_lt;      // bit 2: strict less-than compare
        logic irq_cmp;     // bit 1: interrupt source is compare
        logic en;          // bit 0: run
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cct_regs.sv
// Register file: holds period and control, decodes write strobes for the
// count loader and capture/compare register, raises the software capture
// request, and muxes read data. Assumes W >= CTRL_W.
module cct_regs
    import cct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      capcmp,
    output ctrl_t             ctrl,
    output logic [W-1:0]      period,
    output logic              ld_count,
    output logic              wr_capcmp,
    output logic              sw_cap,
    output logic [W-1:0]      rdata
);

    localparam int PAD_W = W - CTRL_W;

    // Period register: written from the bus at address 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period <= '0;
        else if (wr_en && addr == A_PERIOD)
            period <= wdata;
    end

    // Control register: low bits of the bus at address 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && addr == A_CTRL)
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Strobes: count load on stopped period write, capcmp write, sw capture.
    always_comb begin
        ld_count  = wr_en && (addr == A_PERIOD) && !ctrl.en;
        wr_capcmp = wr_en && (addr == A_CAPCMP);
        sw_cap    = rd_en && (addr == A_COUNT) && ctrl.en;
    end

    // Read data mux.
    always_comb begin
        case (addr)
            A_COUNT:  rdata = count;
            A_PERIOD: rdata = period;
            A_CAPCMP: rdata = capcmp;
            default:  rdata = {{PAD_W{1'b0}}, ctrl};
        endcase
    end

endmodule

// File: rtl/cct_counter.sv
// Down counter with reload from the period register at zero. Loads the
// period directly when the period is written while stopped.
module cct_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         tc_state
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    // Count register: load, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (ld)
            count <= ld_val;
        else if (en)
            count <= (count == ZERO) ? period : count - ONE;
    end

    // Terminal count state: running and at zero.
    assign tc_state = en && (count == ZERO);

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == ZERO) |=> (count == $past(period)));

    // R3
    decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count != ZERO) |=> (count == $past(count) - ONE));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable(count));

endmodule

// File: rtl/cct_capture.sv
// Capture path: merges hardware and software requests ahead of a single
// rising-edge detector, latches the count into the shared capture/compare
// register, and raises a one-cycle capture interrupt. Bus writes to the
// register are accepted only while stopped.
module cct_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         hw_req,
    input  logic         sw_req,
    input  logic         cap_irq_en,
    input  logic         wr_capcmp,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] count,
    output logic [W-1:0] capcmp,
    output logic         cap_irq
);

    logic req;
    logic req_d;
    logic cap_evt;

    // Merged request and its edge.
    always_comb begin
        req     = hw_req | sw_req;
        cap_evt = req & ~req_d;
    end

    // Edge detector history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_d <= 1'b0;
        else
            req_d <= req;
    end

    // Shared register: capture wins over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            capcmp <= '0;
        else if (cap_evt)
            capcmp <= count;
        else if (wr_capcmp && !en)
            capcmp <= wdata;
    end

    // Capture interrupt, aligned with the latched value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_irq <= 1'b0;
        else
            cap_irq <= cap_evt & cap_irq_en;
    end

    // R5
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_d) |=> (capcmp == $past(count)));

    // R5
    no_recap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_d && en) |=> $stable(capcmp));

    // R8
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_capcmp && !(req && !req_d)) |=> $stable(capcmp));

    // R10
    cap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_irq_en && req && !req_d) |=> cap_irq);

endmodule

// File: rtl/cct_irq.sv
// Output stage: compare, terminal-count pulse width, and interrupt source
// selection. Half-width terminal count is gated by the low clock phase.
module cct_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] count,
    input  logic [W-1:0] capcmp,
    input  logic         cmp_lt,
    input  logic         irq_cmp,
    input  logic         tc_full,
    input  logic         tc_state,
    input  logic         cap_irq,
    output logic         tc_out,
    output logic         cmp_out,
    output logic         irq_out
);

    logic tc_d;
    logic cmp_d;
    logic phase_ok;
    logic tc_rise;
    logic cmp_rise;

    // Compare result, forced low while stopped.
    always_comb begin
        if (!en)
            cmp_out = 1'b0;
        else if (cmp_lt)
            cmp_out = count < capcmp;
        else
            cmp_out = count <= capcmp;
    end

    // Previous-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_d  <= 1'b0;
            cmp_d <= 1'b0;
        end else begin
            tc_d  <= tc_state;
            cmp_d <= cmp_out;
        end
    end

    // Pulse shaping and interrupt selection.
    always_comb begin
        phase_ok = tc_full | ~clk;
        tc_out   = tc_state & phase_ok;
        tc_rise  = tc_state & ~tc_d & phase_ok;
        cmp_rise = cmp_out & ~cmp_d;
        irq_out  = (irq_cmp ? cmp_rise : tc_rise) | cap_irq;
    end

    // R9
    cmp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmp && !cap_irq && irq_out) |-> !$past(cmp_out));

    // R7
    stop_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> !cmp_out);

endmodule

// File: rtl/cap_cmp_timer.sv
// Top: byte-wide down-counting timer with capture and compare sharing one
// register. Assumes cap_in is synchronous to clk.
module cap_cmp_timer
    import cct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              cap_in,
    output logic [W-1:0]      rdata,
    output logic              tc_out,
    output logic              cmp_out,
    output logic              irq_out
);

    ctrl_t        ctrl;
    logic [W-1:0] period;
    logic [W-1:0] count;
    logic [W-1:0] capcmp;
    logic         ld_count;
    logic         wr_capcmp;
    logic         sw_cap;
    logic         tc_state;
    logic         cap_irq;

    cct_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count(count), .capcmp(capcmp),
        .ctrl(ctrl), .period(period), .ld_count(ld_count),
        .wr_capcmp(wr_capcmp), .sw_cap(sw_cap), .rdata(rdata)
    );

    cct_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .ld(ld_count),
        .ld_val(wdata), .period(period), .count(count),
        .tc_state(tc_state)
    );

    cct_capture #(.W(W)) u_capture (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .hw_req(cap_in),
        .sw_req(sw_cap), .cap_irq_en(ctrl.cap_irq_en),
        .wr_capcmp(wr_capcmp), .wdata(wdata), .count(count),
        .capcmp(capcmp), .cap_irq(cap_irq)
    );

    cct_irq #(.W(W)) u_irq (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .count(count),
        .capcmp(capcmp), .cmp_lt(ctrl.cmp_lt), .irq_cmp(ctrl.irq_cmp),
        .tc_full(ctrl.tc_full), .tc_state(tc_state), .cap_irq(cap_irq),
        .tc_out(tc_out), .cmp_out(cmp_out), .irq_out(irq_out)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (count == '0 && !irq_out));

endmodule

// File: tb/cap_cmp_timer_tb.sv
`timescale 1ns/1ps
module cap_cmp_timer_tb;

    localparam int W      = 8;
    localparam int CLK_NS = 8;
    localparam logic [W-1:0] C_EN = 8'h01, C_SEL = 8'h02, C_LT = 8'h04,
                             C_CIE = 8'h08, C_FULL = 8'h10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         tc_out, cmp_out, irq_out;

    always #(CLK_NS/2) clk = ~clk;

    cap_cmp_timer #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cap_in(cap_in), .rdata(rdata),
        .tc_out(tc_out), .cmp_out(cmp_out), .irq_out(irq_out)
    );

    // Scoreboard item: kind 0 rdata, 1 tc_out, 2 cmp_out, 3 irq_out.
    typedef struct {
        int           kind;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    // Model state, built from the requirements.
    logic [W-1:0] m_cnt = '0, m_per = '0, m_cc = '0, m_ctrl = '0;
    bit m_tcp = 0, m_cmpp = 0, m_reqp = 0, m_capirq = 0;

    function automatic bit m_cmp();
        if (!m_ctrl[0]) return 1'b0;
        return m_ctrl[2] ? (m_cnt < m_cc) : (m_cnt <= m_cc);
    endfunction

    // Monitor: pops items and compares against live outputs.
    initial begin
        forever begin
            item_t it;
            logic [W-1:0] act;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            case (it.kind)
                0: act = rdata;
                1: act = {{(W-1){1'b0}}, tc_out};
                2: act = {{(W-1){1'b0}}, cmp_out};
                default: act = {{(W-1){1'b0}}, irq_out};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h t=%0t",
                         it.tag, it.kind, act, it.exp, $time);
            end
            sb_q.delete(0);
        end
    end

    // Driver side: push an expectation and wait until the monitor consumed it.
    task automatic expect_item(int kind, logic [W-1:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic check_reg(logic [1:0] a, logic [W-1:0] exp, string tag);
        addr = a;
        #1;
        expect_item(0, exp, tag);
        addr = 2'd0;
    endtask

    // Checks count, outputs and interrupt at a low-phase sample point.
    task automatic check_all(string tag);
        bit tcs, irq_e;
        tcs   = m_ctrl[0] && (m_cnt == '0);
        irq_e = (m_ctrl[1] ? (m_cmp() && !m_cmpp) : (tcs && !m_tcp)) || m_capirq;
        check_reg(2'd0, m_cnt, tag);
        expect_item(1, {{(W-1){1'b0}}, tcs}, tag);
        expect_item(2, {{(W-1){1'b0}}, m_cmp()}, tag);
        expect_item(3, {{(W-1){1'b0}}, irq_e}, tag);
    endtask

    // One clock: advance model with current inputs, then reach +5 (low phase).
    task automatic step();
        bit req, evt, tcs;
        logic [W-1:0] n_cnt, n_per, n_cc, n_ctrl;
        req = cap_in || (rd_en && addr == 2'd0 && m_ctrl[0]);
        evt = req && !m_reqp;
        tcs = m_ctrl[0] && (m_cnt == '0);
        n_cc = m_cc;
        if (evt) n_cc = m_cnt;
        else if (wr_en && addr == 2'd2 && !m_ctrl[0]) n_cc = wdata;
        n_cnt = m_cnt;
        if (wr_en && addr == 2'd1 && !m_ctrl[0]) n_cnt = wdata;
        else if (m_ctrl[0]) n_cnt = (m_cnt == '0) ? m_per : m_cnt - 1'b1;
        n_per  = (wr_en && addr == 2'd1) ? wdata : m_per;
        n_ctrl = (wr_en && addr == 2'd3) ? (wdata & 8'h1f) : m_ctrl;
        m_capirq = evt && m_ctrl[3];
        m_cmpp = m_cmp();
        m_tcp  = tcs;
        m_reqp = req;
        m_cnt = n_cnt; m_per = n_per; m_cc = n_cc; m_ctrl = n_ctrl;
        @(posedge clk);
        #2;
        // R4: half-width terminal count is masked in the high phase
        if (!m_ctrl[4] && m_ctrl[0] && m_cnt == '0)
            expect_item(1, '0, "R4 high-phase");
        #3;
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd_count();
        rd_en = 1'b1; addr = 2'd0;
        step();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1");
        check_reg(2'd1, '0, "R1");
        check_reg(2'd2, '0, "R1");
        check_reg(2'd3, '0, "R1");

        // R2: stopped period write loads count
        wr(2'd1, 8'd5);
        check_reg(2'd0, 8'd5, "R2");
        check_reg(2'd1, 8'd5, "R2");
        // R8: stopped capcmp write accepted
        wr(2'd2, 8'd3);
        check_reg(2'd2, 8'd3, "R8");

        // R3: run, full-width TC, TC interrupt
        wr(2'd3, C_EN | C_FULL);
        check_all("R3");
        for (int i = 0; i < 14; i++) begin
            step();
            check_all("R3");
        end

        // R2: running period write leaves count path alone
        wr(2'd1, 8'd2);
        check_all("R2");
        for (int i = 0; i < 8; i++) begin
            step();
            check_all("R2");
        end

        // R5/R10: hardware capture with capture interrupt
        wr(2'd3, C_EN | C_FULL | C_CIE);
        step(); step();
        held = m_cnt;
        cap_in = 1'b1;
        step();
        check_reg(2'd2, held, "R5");
        check_all("R10");
        step();
        check_all("R10");
        step();
        check_reg(2'd2, held, "R5 held high");
        // R6: software capture masked by high cap_in
        rd_count();
        check_reg(2'd2, held, "R6 masked");
        cap_in = 1'b0;
        step();
        held = m_cnt;
        rd_count();
        check_reg(2'd2, held, "R6 sw capture");
        check_all("R10");

        // R8: running write ignored
        wr(2'd2, 8'hAA);
        check_reg(2'd2, m_cc, "R8 locked");

        // R7/R9: compare, both types, compare interrupt
        wr(2'd3, 8'h00);
        wr(2'd1, 8'd6);
        wr(2'd2, 8'd3);
        wr(2'd3, C_EN | C_SEL);
        for (int i = 0; i < 14; i++) begin
            step();
            check_all("R7 le");
        end
        wr(2'd3, C_EN | C_SEL | C_LT);
        for (int i = 0; i < 14; i++) begin
            step();
            check_all("R9 lt");
        end

        // R4: half-width terminal count with TC interrupt
        wr(2'd3, C_EN);
        for (int i = 0; i < 14; i++) begin
            step();
            check_all("R4");
        end

        // R6: no software capture while stopped
        wr(2'd3, 8'h00);
        wr(2'd1, 8'd9);
        held = m_cc;
        rd_count();
        check_reg(2'd2, held, "R6 stopped");
        check_all("R7 stopped");

        done = 1'b1;
        finish_run();
    end

endmodule